// File: doc/BRIEF.md
# Program ROM bank switching controller

This block sits between a CPU bus and a cartridge's program ROM and work RAM. It watches CPU writes in the upper half of the address space and keeps three writable program bank numbers, a fixed last bank, a window-order mode bit and a work-RAM enable. From the CPU address bits A14:A13 it selects which of four 8 KB windows at 0x8000, 0xA000, 0xC000 and 0xE000 is being accessed. It then drives the ROM bank number for that window on its outputs.

Register selection uses CPU A15:A12 as a group and A11:A10 as a two-bit select. The low address bits A1:A0 play no part in the decode. One bank register shares its select with other logic, and bit A2 picks between the two. Writes that land on character banking, mirroring, nametable or interrupt-counter addresses are ignored here. The RAM window at 0x6000–0x7FFF gets a chip enable and a write enable only while the work-RAM enable is set.

Top module: `prg_bank_ctrl`

## Requirements
- R1: After reset, windows 0..3 return banks 0, 1, 0x1E and 0x1F. The mode is 0, and the work-RAM enable equals the parameter WRAM_RST_EN.
- R2: The decode depends only on A15:A12 and A11:A10, plus A2 for group 0x9 select 3. Other low address bits have no effect on which register is written.
- R3: A write to any address with A15:A12 = 0x8 loads bank register 0, and a write with A15:A12 = 0xA loads bank register 1. Each keeps data bits 4:0.
- R4: A write with A15:A12 = 0x9, A11:A10 = 3 and A2 = 0 loads bank register 2 from data bits 4:0. The same write with A2 = 1 changes no bank.
- R5: A write with A15:A12 = 0x9 and A11:A10 = 2 sets the work-RAM enable from data bit 0 and the mode from data bit 1.
- R6: The window is CPU A14:A13. In mode 0, windows 0, 1, 2 and 3 use registers 0, 1, 2 and 3. In mode 1 they use registers 2, 1, 0 and 3. Register 3 is always 0x1F.
- R7: ram_ce_o is high only when the address is in 0x6000–0x7FFF, the work-RAM enable is set, and a read or write strobe is active. ram_we_o is high only for a write under the same conditions.
- R8: Writes to group 0x9 selects 0 and 1, to groups 0xB–0xF, or below 0x8000 change no bank, mode or enable state.
- R9: A qualified write takes effect at the clock edge on which cpu_wr_i is sampled high. The outputs follow combinationally after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_addr_i | input | 16 | CPU address |
| cpu_data_i | input | 8 | CPU write data |
| cpu_wr_i | input | 1 | CPU write strobe |
| cpu_rd_i | input | 1 | CPU read strobe |
| rom_bank_o | output | 5 | ROM bank number for the addressed window |
| ram_ce_o | output | 1 | Work RAM chip enable |
| ram_we_o | output | 1 | Work RAM write enable |

## Verification
The bench builds the block with 5-bit bank numbers and WRAM_RST_EN set to 0. At this width every one of the 256 data values maps to one of 32 banks, so a full data sweep for each writable register is cheap. With the enable cleared at reset, the gated-off RAM path can be checked before any control write. It also lets the bench observe the enable being set later. All four control values are swept across all four windows, in both RAM enable states.

// File: rtl/prg_bank_pkg.sv
package prg_bank_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic ld_r0;
    logic ld_r1;
    logic ld_r2;
    logic ld_ctrl;
  } wr_sel_t;

  localparam logic [3:0] GRP_R0   = 4'h8;
  localparam logic [3:0] GRP_MISC = 4'h9;
  localparam logic [3:0] GRP_R1   = 4'hA;
  localparam logic [1:0] SEL_CTRL = 2'd2;
  localparam logic [1:0] SEL_R2   = 2'd3;
endpackage

// File: rtl/prg_wr_decode.sv
module prg_wr_decode
  import prg_bank_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  output wr_sel_t           sel_o
);
  logic [3:0] grp;
  logic [1:0] sub;

  assign grp = addr_i[15:12];
  assign sub = addr_i[11:10];

  always_comb begin
    sel_o = '0;
    if (wr_i) begin
      unique case (grp)
        GRP_R0: sel_o.ld_r0 = 1'b1;
        GRP_R1: sel_o.ld_r1 = 1'b1;
        GRP_MISC: begin
          if (sub == SEL_CTRL) sel_o.ld_ctrl = 1'b1;
          // A2 high routes this select to nametable logic
          else if (sub == SEL_R2 && !addr_i[2]) sel_o.ld_r2 = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/prg_bank_regs.sv
module prg_bank_regs
  import prg_bank_pkg::*;
#(
  parameter int BANK_W      = 5,
  parameter bit WRAM_RST_EN = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  wr_sel_t           sel_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [BANK_W-1:0] r0_o,
  output logic [BANK_W-1:0] r1_o,
  output logic [BANK_W-1:0] r2_o,
  output logic              mode_o,
  output logic              wram_en_o
);
  localparam logic [BANK_W-1:0] R0_RST = '0;
  localparam logic [BANK_W-1:0] R1_RST = BANK_W'(1);
  localparam logic [BANK_W-1:0] R2_RST = {{(BANK_W-1){1'b1}}, 1'b0};

  logic [BANK_W-1:0] bank_d;
  assign bank_d = data_i[BANK_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r0_o      <= R0_RST;
      r1_o      <= R1_RST;
      r2_o      <= R2_RST;
      mode_o    <= 1'b0;
      wram_en_o <= WRAM_RST_EN;
    end else begin
      if (sel_i.ld_r0) r0_o <= bank_d;
      if (sel_i.ld_r1) r1_o <= bank_d;
      if (sel_i.ld_r2) r2_o <= bank_d;
      if (sel_i.ld_ctrl) begin
        wram_en_o <= data_i[0];
        mode_o    <= data_i[1];
      end
    end
  end

  p_hold_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == '0) |=> ($stable(r0_o) && $stable(r1_o) && $stable(r2_o)
                       && $stable(mode_o) && $stable(wram_en_o)));
endmodule

// File: rtl/prg_window_map.sv
module prg_window_map #(
  parameter int BANK_W = 5
) (
  input  logic [1:0]        win_i,
  input  logic              mode_i,
  input  logic [BANK_W-1:0] r0_i,
  input  logic [BANK_W-1:0] r1_i,
  input  logic [BANK_W-1:0] r2_i,
  output logic [BANK_W-1:0] bank_o
);
  localparam int NWIN = 4;

  logic [BANK_W-1:0] tbl [NWIN];
  logic [1:0]        idx;

  for (genvar g = 0; g < NWIN; g++) begin : g_tbl
    if (g == 0)      begin : g_r0 assign tbl[g] = r0_i; end
    else if (g == 1) begin : g_r1 assign tbl[g] = r1_i; end
    else if (g == 2) begin : g_r2 assign tbl[g] = r2_i; end
    else             begin : g_fix assign tbl[g] = '1; end
  end

  // mode 1 swaps the even windows 0 and 2
  assign idx    = (mode_i && !win_i[0]) ? (win_i ^ 2'b10) : win_i;
  assign bank_o = tbl[idx];

  always_comb begin
    p_last_fixed_r6: assert (win_i != 2'b11 || bank_o == '1);
  end
endmodule

// File: rtl/prg_bank_ctrl.sv
module prg_bank_ctrl
  import prg_bank_pkg::*;
#(
  parameter int BANK_W      = 5,
  parameter bit WRAM_RST_EN = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       cpu_addr_i,
  input  logic [7:0]        cpu_data_i,
  input  logic              cpu_wr_i,
  input  logic              cpu_rd_i,
  output logic [BANK_W-1:0] rom_bank_o,
  output logic              ram_ce_o,
  output logic              ram_we_o
);
  wr_sel_t           sel;
  logic [BANK_W-1:0] r0, r1, r2;
  logic              mode, wram_en, in_ram;

  prg_wr_decode u_dec (
    .addr_i (cpu_addr_i),
    .wr_i   (cpu_wr_i),
    .sel_o  (sel)
  );

  prg_bank_regs #(.BANK_W(BANK_W), .WRAM_RST_EN(WRAM_RST_EN)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (sel),
    .data_i    (cpu_data_i),
    .r0_o      (r0),
    .r1_o      (r1),
    .r2_o      (r2),
    .mode_o    (mode),
    .wram_en_o (wram_en)
  );

  prg_window_map #(.BANK_W(BANK_W)) u_map (
    .win_i  (cpu_addr_i[14:13]),
    .mode_i (mode),
    .r0_i   (r0),
    .r1_i   (r1),
    .r2_i   (r2),
    .bank_o (rom_bank_o)
  );

  assign in_ram   = (cpu_addr_i[15:13] == 3'b011);
  assign ram_ce_o = in_ram && wram_en && (cpu_rd_i || cpu_wr_i);
  assign ram_we_o = in_ram && wram_en && cpu_wr_i;

  p_we_in_ce_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> ram_ce_o);
  p_ram_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wram_en |-> (!ram_ce_o && !ram_we_o));
  p_ctrl_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_wr_i && cpu_addr_i[15:10] == 6'b100110)
      |=> (wram_en == $past(cpu_data_i[0]) && mode == $past(cpu_data_i[1])));
  p_nt_sub_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_wr_i && cpu_addr_i[15:10] == 6'b100111 && cpu_addr_i[2]) |=> $stable(r2));
endmodule

// File: tb/prg_bank_ctrl_test.sv
module prg_bank_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  data = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [4:0]  bank;
  logic        ce, we;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  logic [4:0] m_r0 = 5'd0, m_r1 = 5'd1, m_r2 = 5'd30;
  logic       m_mode = 1'b0, m_wen = 1'b0;

  always #4 clk = ~clk;

  prg_bank_ctrl #(.BANK_W(5), .WRAM_RST_EN(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .cpu_addr_i(addr), .cpu_data_i(data),
    .cpu_wr_i(wr), .cpu_rd_i(rd), .rom_bank_o(bank), .ram_ce_o(ce), .ram_we_o(we)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_bank(input logic [1:0] w);
    case (w)
      2'd0: return m_mode ? m_r2 : m_r0;
      2'd1: return m_r1;
      2'd2: return m_mode ? m_r0 : m_r2;
      default: return 5'h1F;
    endcase
  endfunction

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; data = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic check_win(input logic [1:0] w, input string req);
    addr = {1'b1, w, 13'h0155};
    rd = 1'b1;
    #1;
    chk(bank == exp_bank(w), req, bank, exp_bank(w));
    rd = 1'b0;
  endtask

  task automatic check_all(input string req);
    for (int w = 0; w < 4; w++) check_win(2'(w), req);
  endtask

  task automatic check_ram(input string req);
    addr = 16'h6ABC; rd = 1'b1; wr = 1'b0; #1;
    chk(ce == m_wen && we == 1'b0, req, {ce, we}, {m_wen, 1'b0});
    rd = 1'b0; #1;
    chk(ce == 1'b0, req, ce, 0);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check_all("R1");
    check_ram("R1");
    rst_ni = 1'b1;
    @(negedge clk);
    check_all("R1");

    // R3 / R2: register 0 and 1 over all data, low address bits varied
    for (int v = 0; v < 256; v++) begin
      cpu_write(16'h8000 | 16'(v[3:2]) << 10 | 16'(v[1:0]) | 16'(v[6:4]) << 5, 8'(v));
      m_r0 = 5'(v);
      check_win(2'd0, "R3");
      cpu_write(16'hA000 | 16'(v[3:2]) << 10 | 16'(v[1:0]), 8'(255 - v));
      m_r1 = 5'(255 - v);
      check_win(2'd1, "R2");
    end

    // R4: register 2 with A2 clear, ignored with A2 set
    for (int v = 0; v < 256; v++) begin
      cpu_write(16'h9C00 | 16'(v[1:0]) | 16'(v[7:5]) << 3, 8'(v));
      m_r2 = 5'(v);
      check_win(2'd2, "R4");
      cpu_write(16'h9C04 | 16'(v[1:0]), 8'(v ^ 8'h0A));
      check_win(2'd2, "R4");
    end

    // R5 / R6 / R7: all control values, all windows, RAM gating
    cpu_write(16'h8000, 8'd3);  m_r0 = 5'd3;
    cpu_write(16'hA000, 8'd7);  m_r1 = 5'd7;
    cpu_write(16'h9C00, 8'd12); m_r2 = 5'd12;
    for (int c = 0; c < 8; c++) begin
      cpu_write(16'h9800 | 16'(c & 3), 8'(c));
      m_wen = c[0]; m_mode = c[1];
      check_all("R6");
      check_ram("R5");
      @(negedge clk);
      addr = 16'h7FFF; wr = 1'b1; #1;
      chk(ce == m_wen && we == m_wen, "R7", {ce, we}, {m_wen, m_wen});
      addr = 16'h5FFF; #1;
      chk(ce == 1'b0 && we == 1'b0, "R7", {ce, we}, 0);
      addr = 16'h8000; #1;
      chk(ce == 1'b0 && we == 1'b0, "R7", {ce, we}, 0);
      wr = 1'b0;
      check_all("R8");
    end

    // R8: writes to ignored addresses
    cpu_write(16'h9800, 8'd3); m_wen = 1'b1; m_mode = 1'b1;
    for (int a = 0; a < 64; a++) begin
      logic [15:0] ia;
      ia = 16'(a) << 10;
      if (ia[15:12] == 4'h8 || ia[15:12] == 4'hA) continue;
      if (ia[15:12] == 4'h9 && ia[11:10] >= 2) continue;
      cpu_write(ia | 16'h0003, 8'hFC);
      check_all("R8");
      check_ram("R8");
    end

    // R9: state changes at the sampling edge, not before
    @(negedge clk);
    addr = 16'h8000; data = 8'd21; wr = 1'b1; #1;
    chk(bank == m_r2, "R9", bank, m_r2);
    @(posedge clk); #1;
    wr = 1'b0; m_r0 = 5'd21;
    addr = 16'hC000; #1;
    chk(bank == 5'd21, "R9", bank, 21);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule